// File: doc/BRIEF.md
# Pixel Window Read Buffer

This block sits between a pixel access port and a byte-addressed memory. It keeps a copy of one aligned 4096-byte window of memory and serves 8, 16 and 32-bit reads from that copy. When a read falls outside the window, the block first pulls the whole window in from memory as a train of fixed-length bursts. Only then does it answer. Writes never allocate. They pass straight to the memory write port with byte enables, and each one throws the window away, so a later read never sees stale bytes.

A pixel format without alpha is handled by two special forms. A 4-byte read with the no-alpha flag returns the stored word with its top byte forced to all ones. A 3-byte write stores only the low three bytes of a word. Requests use a valid/ready handshake. Every accepted request, read or write, gets a one-cycle response pulse carrying data or an error flag.

Top module: `span_window_buf`

## Requirements
- R1: After reset the window is invalid, no response or memory request is active, and the first read always causes a refill.
- R2: A read whose address bits 31:12 differ from the held window base, or any read while the window is invalid, loads the window with that base. The load is 64 read bursts of eight 64-bit beats each, at increasing 64-byte-aligned addresses covering base*4096 up to base*4096+4095. `req_ready` stays low until the last beat has arrived.
- R3: A read that hits the window is accepted without any memory traffic. `rsp_valid` is high exactly in the cycle after each accepted request.
- R4: `req_size` encodes the byte count minus one (0 = 1 byte, 1 = 2 bytes, 2 = 3 bytes, 3 = 4 bytes). Read data is little-endian from byte offset `req_addr[11:0]` of the window, zero-extended to 32 bits.
- R5: A 4-byte read with `req_noalpha` set returns bits 31:24 as 0xFF. `req_noalpha` has no effect on 1-byte and 2-byte reads.
- R6: A write drives `mem_wr_addr` = `req_addr` with bits 2:0 cleared. Byte i of `req_wdata` goes on lane `req_addr[2:0]`+i, and exactly `req_size`+1 enable bits are set starting at that lane. A write never starts a refill.
- R7: Every accepted write invalidates the window, so the next read, even to the same window, refills.
- R8: A request presented during a refill is held with `req_ready` low and no memory write. A write held this way is taken after the refill and then invalidates the window.
- R9: A 2-byte access at an odd address, a 3 or 4-byte access whose address bits 1:0 are not zero, and any 3-byte read are accepted at once and answered with `rsp_err`=1. They cause no memory access and leave the window unchanged.
- R10: A valid write is accepted only in a cycle where `mem_wr_ready` is high. Its response carries `rsp_rdata` = 0 and `rsp_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Byte count minus one |
| req_noalpha | input | 1 | Force top byte of a 4-byte read to 0xFF |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_err | output | 1 | Request was misaligned or illegal |
| rsp_rdata | output | 32 | Read data |
| mem_rd_req_valid | output | 1 | Burst read request |
| mem_rd_req_ready | input | 1 | Burst request taken |
| mem_rd_addr | output | 32 | Burst start address, 64-byte aligned |
| mem_rd_data_valid | input | 1 | Burst beat present |
| mem_rd_data | input | 64 | Burst beat data |
| mem_wr_valid | output | 1 | Write request |
| mem_wr_ready | input | 1 | Write taken |
| mem_wr_addr | output | 32 | Write address, 8-byte aligned |
| mem_wr_data | output | 64 | Write data by lane |
| mem_wr_be | output | 8 | Write byte enables |

## Verification
On every cycle the assertions check the following. Requests are blocked while a burst is outstanding. Memory writes never overlap a refill. Burst addresses are 64-byte aligned. The number of write enables matches the size. An accepted write clears the window. Responses line up with acceptance, and the no-alpha top byte is 0xFF. Other behaviour only shows in the bench's scenarios against a byte-level memory model: whether a read hits or refills, the burst order, little-endian lane selection, a write swapped in while a refill runs, and error requests leaving the window intact.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_3B = 2'd2,
    SZ_4B = 2'd3
  } swb_size_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ISSUE = 2'd1,
    FS_RECV  = 2'd2
  } swb_fill_e;

  // Accesses must sit on their own size; 3-byte accesses sit on a word.
  function automatic logic swb_misaligned(input logic [1:0] size, input logic [1:0] lo);
    case (size)
      SZ_1B:   return 1'b0;
      SZ_2B:   return lo[0];
      default: return lo != 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/swb_tag.sv
module swb_tag #(
  parameter int BASE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_base,
  input  logic [BASE_W-1:0] new_base,
  input  logic              set_valid,
  input  logic              clear_valid,
  input  logic [BASE_W-1:0] probe_base,
  output logic              hit,
  output logic              valid_q
);

  logic [BASE_W-1:0] base_q, base_d;
  logic              valid_d;

  always_comb begin
    base_d  = base_q;
    valid_d = valid_q;
    if (load_base) begin
      base_d  = new_base;
      valid_d = 1'b0;
    end
    if (clear_valid) valid_d = 1'b0;
    if (set_valid)   valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      base_q  <= base_d;
      valid_q <= valid_d;
    end
  end

  assign hit = valid_q && (base_q == probe_base);

endmodule

// File: rtl/swb_refill.sv
module swb_refill
  import swb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int BUS_BYTES   = 8,
  parameter int BURST_BEATS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [ADDR_W-OFF_W-1:0]        start_base,
  output logic                           mem_rd_req_valid,
  input  logic                           mem_rd_req_ready,
  output logic [ADDR_W-1:0]              mem_rd_addr,
  input  logic                           mem_rd_data_valid,
  output logic                           fill_we,
  output logic [OFF_W-$clog2(BUS_BYTES)-1:0] fill_idx,
  output logic                           busy,
  output logic                           done
);

  localparam int LANE_W  = $clog2(BUS_BYTES);
  localparam int WORDS   = (1 << OFF_W) / BUS_BYTES;
  localparam int BEAT_W  = $clog2(BURST_BEATS);
  localparam int NBURST  = WORDS / BURST_BEATS;
  localparam int BURST_W = $clog2(NBURST);

  swb_fill_e                 state_q, state_d;
  logic [ADDR_W-OFF_W-1:0]   base_q, base_d;
  logic [BURST_W-1:0]        burst_q, burst_d;
  logic [BEAT_W-1:0]         beat_q, beat_d;
  logic                      last_beat, last_burst;

  assign last_beat  = beat_q == BEAT_W'(BURST_BEATS - 1);
  assign last_burst = burst_q == BURST_W'(NBURST - 1);

  assign mem_rd_req_valid = state_q == FS_ISSUE;
  assign mem_rd_addr      = {base_q, burst_q, {(BEAT_W + LANE_W){1'b0}}};
  assign fill_we          = (state_q == FS_RECV) && mem_rd_data_valid;
  assign fill_idx         = {burst_q, beat_q};
  assign done             = fill_we && last_beat && last_burst;
  assign busy             = state_q != FS_IDLE;

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    burst_d = burst_q;
    beat_d  = beat_q;
    case (state_q)
      FS_IDLE: if (start) begin
        base_d  = start_base;
        burst_d = '0;
        beat_d  = '0;
        state_d = FS_ISSUE;
      end
      FS_ISSUE: if (mem_rd_req_ready) state_d = FS_RECV;
      FS_RECV: if (mem_rd_data_valid) begin
        beat_d = beat_q + 1'b1;
        if (last_beat) begin
          beat_d = '0;
          if (last_burst) state_d = FS_IDLE;
          else begin
            burst_d = burst_q + 1'b1;
            state_d = FS_ISSUE;
          end
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      base_q  <= '0;
      burst_q <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      burst_q <= burst_d;
      beat_q  <= beat_d;
    end
  end

endmodule

// File: rtl/swb_lanes.sv
module swb_lanes
  import swb_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int BUS_BYTES = 8
) (
  input  logic                               clk,
  input  logic                               fill_we,
  input  logic [OFF_W-$clog2(BUS_BYTES)-1:0] fill_idx,
  input  logic [BUS_BYTES*8-1:0]             fill_data,
  input  logic [OFF_W-1:0]                   acc_off,
  input  logic [1:0]                         acc_size,
  input  logic                               rd_noalpha,
  output logic [31:0]                        rd_value,
  input  logic [31:0]                        wr_word,
  output logic [BUS_BYTES*8-1:0]             wr_bus_data,
  output logic [BUS_BYTES-1:0]               wr_bus_be
);

  localparam int LANE_W = $clog2(BUS_BYTES);
  localparam int WORDS  = (1 << OFF_W) / BUS_BYTES;
  localparam int BUS_W  = BUS_BYTES * 8;

  logic [BUS_W-1:0]  store_q [WORDS];
  logic [BUS_W-1:0]  word;
  logic [LANE_W-1:0] lane;
  logic [7:0]        rbyte [4];
  logic [3:0]        be4;

  always_ff @(posedge clk) begin
    if (fill_we) store_q[fill_idx] <= fill_data;
  end

  assign lane = acc_off[LANE_W-1:0];
  assign word = store_q[acc_off[OFF_W-1:LANE_W]];

  // Byte k of the access sits on lane (lane + k); aligned accesses never wrap.
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      rbyte[k] = word[8 * int'(lane + LANE_W'(k)) +: 8];
    end
  end

  always_comb begin
    case (acc_size)
      SZ_1B:   rd_value = {24'h0, rbyte[0]};
      SZ_2B:   rd_value = {16'h0, rbyte[1], rbyte[0]};
      default: rd_value = {(rd_noalpha && acc_size == SZ_4B) ? 8'hFF : rbyte[3],
                           rbyte[2], rbyte[1], rbyte[0]};
    endcase
  end

  always_comb begin
    case (acc_size)
      SZ_1B:   be4 = 4'h1;
      SZ_2B:   be4 = 4'h3;
      SZ_3B:   be4 = 4'h7;
      default: be4 = 4'hF;
    endcase
  end

  assign wr_bus_be   = BUS_BYTES'(be4) << lane;
  assign wr_bus_data = BUS_W'(wr_word) << {lane, 3'b000};

endmodule

// File: rtl/span_window_buf.sv
module span_window_buf
  import swb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WIN_BYTES   = 4096,
  parameter int BUS_BYTES   = 8,
  parameter int BURST_BEATS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic                   req_noalpha,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [31:0]            rsp_rdata,
  output logic                   mem_rd_req_valid,
  input  logic                   mem_rd_req_ready,
  output logic [ADDR_W-1:0]      mem_rd_addr,
  input  logic                   mem_rd_data_valid,
  input  logic [BUS_BYTES*8-1:0] mem_rd_data,
  output logic                   mem_wr_valid,
  input  logic                   mem_wr_ready,
  output logic [ADDR_W-1:0]      mem_wr_addr,
  output logic [BUS_BYTES*8-1:0] mem_wr_data,
  output logic [BUS_BYTES-1:0]   mem_wr_be
);

  localparam int OFF_W  = $clog2(WIN_BYTES);
  localparam int LANE_W = $clog2(BUS_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = OFF_W - LANE_W;

  logic             req_err, hit, win_valid, busy, done, miss, accept, kill;
  logic             fill_we;
  logic [IDX_W-1:0] fill_idx;
  logic [31:0]      rd_value;
  logic             rsp_valid_d, rsp_err_d;
  logic [31:0]      rsp_rdata_d;

  assign req_err = swb_misaligned(req_size, req_addr[1:0]) ||
                   (!req_write && req_size == SZ_3B);
  assign miss    = req_valid && !req_write && !req_err && !hit && !busy;
  assign req_ready = !busy && !miss && (!req_write || req_err || mem_wr_ready);
  assign accept  = req_valid && req_ready;
  assign kill    = accept && req_write && !req_err;

  assign mem_wr_valid = req_valid && req_write && !req_err && !busy;
  assign mem_wr_addr  = {req_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

  swb_tag #(.BASE_W(BASE_W)) u_tag (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_base   (miss),
    .new_base    (req_addr[ADDR_W-1:OFF_W]),
    .set_valid   (done),
    .clear_valid (kill),
    .probe_base  (req_addr[ADDR_W-1:OFF_W]),
    .hit         (hit),
    .valid_q     (win_valid)
  );

  swb_refill #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BUS_BYTES(BUS_BYTES), .BURST_BEATS(BURST_BEATS)
  ) u_refill (
    .clk               (clk),
    .rst_n             (rst_n),
    .start             (miss),
    .start_base        (req_addr[ADDR_W-1:OFF_W]),
    .mem_rd_req_valid  (mem_rd_req_valid),
    .mem_rd_req_ready  (mem_rd_req_ready),
    .mem_rd_addr       (mem_rd_addr),
    .mem_rd_data_valid (mem_rd_data_valid),
    .fill_we           (fill_we),
    .fill_idx          (fill_idx),
    .busy              (busy),
    .done              (done)
  );

  swb_lanes #(.OFF_W(OFF_W), .BUS_BYTES(BUS_BYTES)) u_lanes (
    .clk         (clk),
    .fill_we     (fill_we),
    .fill_idx    (fill_idx),
    .fill_data   (mem_rd_data),
    .acc_off     (req_addr[OFF_W-1:0]),
    .acc_size    (req_size),
    .rd_noalpha  (req_noalpha),
    .rd_value    (rd_value),
    .wr_word     (req_wdata),
    .wr_bus_data (mem_wr_data),
    .wr_bus_be   (mem_wr_be)
  );

  always_comb begin
    rsp_valid_d = accept;
    rsp_err_d   = accept && req_err;
    rsp_rdata_d = (accept && !req_write && !req_err) ? rd_value : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

endmodule

// File: rtl/span_window_buf_chk.sv
module span_window_buf_chk #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8,
  parameter int BURST_LG  = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [1:0]           req_size,
  input logic                 req_noalpha,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 rsp_valid,
  input logic                 rsp_err,
  input logic [31:0]          rsp_rdata,
  input logic                 mem_rd_req_valid,
  input logic [ADDR_W-1:0]    mem_rd_addr,
  input logic                 mem_wr_valid,
  input logic [BUS_BYTES-1:0] mem_wr_be,
  input logic                 win_valid
);

  logic acc, bad;
  assign acc = req_valid && req_ready;
  assign bad = (req_size == 2'd1 && req_addr[0]) ||
               (req_size[1] && req_addr[1:0] != 2'b00) ||
               (!req_write && req_size == 2'd2);

  always @(posedge clk) begin
    if (!rst_n) p_window_invalid_in_reset_r1: assert (!win_valid);
  end

  p_fill_blocks_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid |-> !req_ready);

  p_burst_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid |-> mem_rd_addr[BURST_LG-1:0] == '0);

  p_rsp_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  p_no_rsp_without_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);

  p_noalpha_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_noalpha && req_size == 2'd3 && !bad)
    |=> rsp_rdata[31:24] == 8'hFF);

  p_write_be_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> $countones(mem_wr_be) == int'(req_size) + 1);

  p_write_kills_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && req_ready) |=> !win_valid);

  p_no_write_in_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid |-> !mem_wr_valid);

  p_err_no_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad) |-> !mem_wr_valid);

  p_err_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bad) |=> rsp_err);

endmodule

bind span_window_buf span_window_buf_chk #(
  .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .BURST_LG($clog2(BUS_BYTES * BURST_BEATS))
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_write        (req_write),
  .req_size         (req_size),
  .req_noalpha      (req_noalpha),
  .req_addr         (req_addr),
  .rsp_valid        (rsp_valid),
  .rsp_err          (rsp_err),
  .rsp_rdata        (rsp_rdata),
  .mem_rd_req_valid (mem_rd_req_valid),
  .mem_rd_addr      (mem_rd_addr),
  .mem_wr_valid     (mem_wr_valid),
  .mem_wr_be        (mem_wr_be),
  .win_valid        (win_valid)
);

// File: tb/span_window_buf_bench.sv
module span_window_buf_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_noalpha = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mem_rd_req_valid, mem_wr_valid;
  logic        mem_rd_req_ready = 1'b1, mem_wr_ready = 1'b1;
  logic        mem_rd_data_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic [31:0] mem_rd_addr, mem_wr_addr;
  logic [63:0] mem_wr_data;
  logic [7:0]  mem_wr_be;

  int checks = 0, fails = 0;
  int bursts_seen = 0;
  int beats_left = 0;
  logic [31:0] cur_burst;
  logic [7:0]  mm [int unsigned];
  logic        win_ok = 1'b0;
  logic [19:0] win_base = '0;

  always #5 clk = ~clk;

  span_window_buf u_span_window_buf (.*);

  function automatic logic [7:0] get_b(input logic [31:0] a);
    if (mm.exists(a)) return mm[a];
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory responder: bursts of eight beats starting the cycle after the handshake.
  always @(negedge clk) begin
    if (beats_left > 0) begin
      logic [31:0] a;
      a = cur_burst + 32'(8 * (8 - beats_left));
      mem_rd_data_valid = 1'b1;
      for (int i = 0; i < 8; i++) mem_rd_data[8*i +: 8] = get_b(a + 32'(i));
      beats_left--;
    end else mem_rd_data_valid = 1'b0;
    if (mem_rd_req_valid && rst_n) begin
      chk(mem_rd_addr[11:0] == 12'((bursts_seen % 64) * 64), "R2 burst order",
          64'(mem_rd_addr), 64'((bursts_seen % 64) * 64));
      cur_burst  = mem_rd_addr;
      beats_left = 8;
      bursts_seen++;
    end
  end

  function automatic logic is_bad(input logic w, input logic [1:0] sz, input logic [31:0] a);
    return (sz == 2'd1 && a[0]) || (sz[1] && a[1:0] != 2'b00) || (!w && sz == 2'd2);
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic na, input logic [31:0] a);
    logic [31:0] v;
    v = {get_b(a + 3), get_b(a + 2), get_b(a + 1), get_b(a)};
    case (sz)
      2'd0:    return {24'h0, v[7:0]};
      2'd1:    return {16'h0, v[15:0]};
      default: return na ? {8'hFF, v[23:0]} : v;
    endcase
  endfunction

  // Check lanes and enables of the write on the bus, then commit it to the model.
  task automatic take_write(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd);
    logic [7:0]  ebe;
    logic [63:0] emask, edata;
    ebe   = 8'((4'b1111 >> (3 - sz))) << a[2:0];
    edata = 64'(wd) << (8 * a[2:0]);
    emask = '0;
    for (int i = 0; i < 8; i++) if (ebe[i]) emask[8*i +: 8] = 8'hFF;
    chk(mem_wr_addr == {a[31:3], 3'b000}, "R6 write address", 64'(mem_wr_addr), 64'({a[31:3], 3'b000}));
    chk(mem_wr_be == ebe, "R6 byte enables", 64'(mem_wr_be), 64'(ebe));
    chk((mem_wr_data & emask) == (edata & emask), "R6 write lanes", mem_wr_data & emask, edata & emask);
    for (int i = 0; i <= int'(sz); i++) mm[a + 32'(i)] = wd[8*i +: 8];
  endtask

  task automatic run_op(input logic w, input logic [1:0] sz, input logic na,
                        input logic [31:0] a, input logic [31:0] wd, input string tag);
    int b0, exp_delta;
    logic bad;
    logic [31:0] er;
    bad = is_bad(w, sz, a);
    b0 = bursts_seen;
    exp_delta = (!w && !bad && !(win_ok && win_base == a[31:12])) ? 64 : 0;
    er = (w || bad) ? 32'h0 : exp_read(sz, na, a);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_noalpha = na;
    req_addr = a; req_wdata = wd;
    forever begin
      mem_wr_ready = ($urandom_range(0, 2) != 0);
      #2;
      if (w && !bad && !mem_wr_ready)
        chk(!req_ready, {tag, " R10 held without write ready"}, 64'(req_ready), 64'(0));
      if (req_ready) break;
      @(negedge clk);
    end
    if (w && !bad) take_write(sz, a, wd);
    @(posedge clk);
    #2;
    req_valid = 1'b0;
    chk(rsp_valid, {tag, " R3 response pulse"}, 64'(rsp_valid), 64'(1));
    chk(rsp_err == bad, {tag, " R9 error flag"}, 64'(rsp_err), 64'(bad));
    chk(rsp_rdata == er, {tag, " R4 read data"}, 64'(rsp_rdata), 64'(er));
    chk(bursts_seen - b0 == exp_delta, {tag, " R2 refill count"}, 64'(bursts_seen - b0), 64'(exp_delta));
    if (w && !bad) win_ok = 1'b0;
    else if (!w && !bad) begin win_ok = 1'b1; win_base = a[31:12]; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    chk(!rsp_valid && !mem_rd_req_valid && !mem_wr_valid, "R1 reset outputs idle",
        64'({rsp_valid, mem_rd_req_valid, mem_wr_valid}), 64'(0));
    @(negedge clk); rst_n = 1'b1;

    run_op(1'b0, 2'd3, 1'b0, 32'h0000_0010, 0, "R1 first read refills");
    run_op(1'b0, 2'd0, 1'b0, 32'h0000_0FFF, 0, "R3 R4 hit last byte");
    run_op(1'b0, 2'd1, 1'b0, 32'h0000_0FFE, 0, "R4 halfword top");
    run_op(1'b0, 2'd3, 1'b1, 32'h0000_0020, 0, "R5 noalpha word");
    run_op(1'b0, 2'd1, 1'b1, 32'h0000_0022, 0, "R5 noalpha ignored on halfword");
    run_op(1'b0, 2'd1, 1'b0, 32'h0000_0021, 0, "R9 odd halfword");
    run_op(1'b0, 2'd2, 1'b0, 32'h0000_0024, 0, "R9 three-byte read");
    run_op(1'b1, 2'd3, 1'b0, 32'h0000_0022, 32'h1111_2222, "R9 misaligned write");
    run_op(1'b0, 2'd3, 1'b0, 32'h0000_0020, 0, "R9 window kept");
    run_op(1'b1, 2'd2, 1'b0, 32'h0000_0044, 32'hAABB_CCDD, "R6 three-byte write");
    run_op(1'b0, 2'd3, 1'b0, 32'h0000_0044, 0, "R7 read after write refills");
    run_op(1'b1, 2'd0, 1'b0, 32'h0000_0047, 32'h0000_0077, "R6 byte write lane 7");
    run_op(1'b0, 2'd3, 1'b0, 32'h0000_0044, 0, "R7 refill sees byte write");

    // R8: a read starts a refill, then the request turns into a write while bursts run.
    begin
      int b0;
      b0 = bursts_seen;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_size = 2'd3; req_noalpha = 1'b0;
      req_addr = 32'h0000_5000;
      repeat (20) @(negedge clk);
      req_write = 1'b1; req_addr = 32'h0000_5008; req_wdata = 32'hCAFE_F00D;
      mem_wr_ready = 1'b1;
      #2;
      chk(!mem_wr_valid && !req_ready, "R8 write held during refill",
          64'({mem_wr_valid, req_ready}), 64'(0));
      while (!req_ready) begin @(negedge clk); #2; end
      chk(bursts_seen - b0 == 64, "R8 refill finished before write", 64'(bursts_seen - b0), 64'(64));
      take_write(2'd3, 32'h0000_5008, 32'hCAFE_F00D);
      @(posedge clk); #2;
      req_valid = 1'b0;
      chk(rsp_valid && rsp_rdata == 0 && !rsp_err, "R10 write response",
          64'({rsp_valid, rsp_err, rsp_rdata}), 64'({1'b1, 1'b0, 32'h0}));
      win_ok = 1'b0;
    end
    run_op(1'b0, 2'd3, 1'b0, 32'h0000_5008, 0, "R8 R7 read after held write");

    for (int n = 0; n < 200; n++) begin
      logic w, na;
      logic [1:0] sz;
      logic [31:0] a;
      w  = ($urandom_range(0, 99) < 15);
      sz = 2'($urandom_range(0, 3));
      na = 1'($urandom);
      if ($urandom_range(0, 99) < 80 && win_ok) a = {win_base, 12'h0};
      else a = ($urandom_range(0, 1) != 0) ? 32'h0ABC_D000 : 32'h0000_1000;
      a[11:0] = 12'($urandom);
      if ($urandom_range(0, 9) != 0) begin
        if (sz == 2'd1) a[0] = 1'b0;
        if (sz[1]) a[1:0] = 2'b00;
        if (!w && sz == 2'd2) sz = 2'd3;
      end
      run_op(w, sz, na, a, $urandom, "R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule